// File: doc/BRIEF.md
# Failure Bitmap Diagnosis Logger

This block sits beside a memory self-test engine that compares every data bit of a word in parallel, with one comparator per bit. Whenever a comparison fails, the engine presents the failing row, bank and column select together with a vector that has one bit per comparator. The logger turns each failing comparator into a physical location: a word address and a physical data bit index. It writes these locations, in order, into a small log that a diagnosis flow reads back after the run to build a bitmap of failing cells.

The word address is built from the high row bits, then the bank bits, then the low row bits. The column select is left out of the address because it chooses among interleaved bits inside the word. A parameter mask can invert chosen row bits to follow a physical row scramble. The bit index is the comparator number times the column mux factor, plus the column select, plus a fixed count of spare bits that sit ahead of the regular bits in a repairable array. When there is no column mux, the bit index is the comparator number plus the spare count.

At the start of each run the block loads an error limit. Once the number of logged failing bits reaches that limit, it raises a stop request so the engine halts at the Nth error. Only the first few failures are stored. Failures that arrive after the log is full only increase an overflow count.

Top module: `fail_bitmap_logger`

## Requirements
- R1: The word address is {row_hi, bank, row_lo}. row_lo is the low ROW_LO_W bits of the (possibly inverted) row, and row_hi is the remaining upper row bits. The column select plays no part in the address.
- R2: With COL_W > 0, the bit index is cmp * 2^COL_W + col + SPARE_BITS. With COL_W = 0, it is cmp + SPARE_BITS and fail_col is ignored.
- R3: Each row bit whose bit in ROW_INV_MASK is 1 is inverted before the address is assembled.
- R4: At most one failing bit is logged per cycle, lowest comparator index first. fail_ready is low while bits of an accepted vector are still waiting, and a vector accepted with fail_ready high has its first bit logged by the next clock edge.
- R5: The log keeps the first LOG_DEPTH failing bits in arrival order. Entry i is read combinationally through rd_idx. rd_valid is high only when i < log_cnt, and rd_addr and rd_bit read zero when it is low.
- R6: Each failing bit processed while the log is full adds one to ovf_cnt, which saturates. It leaves the stored entries unchanged.
- R7: An error counter counts every processed failing bit. stop_req rises after the clock edge on which the count reaches a nonzero err_limit, and stays high until the next run_start. A limit of 0 never requests a stop.
- R8: run_start clears the log, ovf_cnt, the error count, stop_req and any waiting bits, and loads err_limit. A failure presented in the same cycle is dropped.
- R9: After reset, log_cnt and ovf_cnt are 0, stop_req is low and fail_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_start | input | 1 | Starts a run: clears state and loads the limit |
| err_limit | input | CNT_W | Error count that triggers the stop request (0 = none) |
| fail_valid | input | 1 | A failing comparison is presented |
| fail_row | input | ROW_W | Row address of the failing word |
| fail_bank | input | BANK_W | Bank address of the failing word |
| fail_col | input | max(COL_W,1) | Column mux select (ignored when COL_W = 0) |
| fail_vec | input | CMP_N | One bit per comparator, 1 = miscompare |
| fail_ready | output | 1 | Block can accept a new failing vector |
| stop_req | output | 1 | Error limit reached; halt the self-test |
| rd_idx | input | clog2(LOG_DEPTH) | Log entry to read |
| rd_valid | output | 1 | Selected entry holds a logged failure |
| rd_addr | output | ROW_W+BANK_W | Word address of the selected entry |
| rd_bit | output | clog2(CMP_N*2^COL_W+SPARE_BITS) | Physical bit index of the selected entry |
| log_cnt | output | clog2(LOG_DEPTH+1) | Number of stored entries |
| ovf_cnt | output | CNT_W | Failing bits dropped because the log was full |

## Verification
A wrong bit in the waiting-vector register shows up within a few cycles as a missing, extra or reordered log entry, or as fail_ready staying low. Both are caught by reading the log back after each scenario. A fault in the address or bit arithmetic appears in the very next log entry as a wrong rd_addr or rd_bit for a known injected row, bank, column and comparator. This is checked for the interleaved default configuration and for a configuration with no column mux and an inverted row bit. A wrong error count or limit register shows up as stop_req rising one fail too early or too late, or staying low at a limit of 0 only when it should.

// File: rtl/fbl_pkg.sv
package fbl_pkg;

   typedef enum logic {
      SRC_INPUT = 1'b0,
      SRC_PEND  = 1'b1
   } fbl_src_e;

   function automatic int fbl_w(input int n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/fbl_addr_map.sv
module fbl_addr_map #(
   parameter int          ROW_W        = 6,
   parameter int          ROW_LO_W     = 2,
   parameter int          BANK_W       = 3,
   parameter int          COL_W        = 2,
   parameter int          COL_PW       = 2,
   parameter int          IDX_W        = 5,
   parameter int          SPARE_BITS   = 4,
   parameter logic [31:0] ROW_INV_MASK = '0,
   parameter int          ADDR_W       = 9,
   parameter int          BIT_W        = 8
) (
   input  logic [ROW_W-1:0]  row,
   input  logic [BANK_W-1:0] bank,
   input  logic [COL_PW-1:0] col,
   input  logic [IDX_W-1:0]  cmp_idx,
   output logic [ADDR_W-1:0] word_addr,
   output logic [BIT_W-1:0]  bit_idx
);

   localparam logic [ROW_W-1:0] INV    = ROW_INV_MASK[ROW_W-1:0];
   localparam logic [ROW_W-1:0] LO_MSK = ROW_W'((64'(1) << ROW_LO_W) - 64'(1));
   localparam int               HI_SH  = BANK_W + ROW_LO_W;

   logic [ROW_W-1:0]  phys_row;
   logic [ADDR_W-1:0] hi_part;
   logic [ADDR_W-1:0] bank_part;
   logic [ADDR_W-1:0] lo_part;

   // scramble: selected row bits flip before assembly
   assign phys_row  = row ^ INV;
   assign hi_part   = ADDR_W'(phys_row >> ROW_LO_W) << HI_SH;
   assign bank_part = ADDR_W'(bank) << ROW_LO_W;
   assign lo_part   = ADDR_W'(phys_row & LO_MSK);
   assign word_addr = hi_part | bank_part | lo_part;

   generate
      if (COL_W > 0) begin : g_mux
         // interleave: comparator k of column c sits at k*M + c
         assign bit_idx = BIT_W'({cmp_idx, col[COL_W-1:0]}) + BIT_W'(SPARE_BITS);
      end else begin : g_nomux
         logic unused_col;
         assign unused_col = ^col;
         assign bit_idx    = BIT_W'(cmp_idx) + BIT_W'(SPARE_BITS);
      end
   endgenerate

endmodule

// File: rtl/fbl_pick.sv
module fbl_pick
   import fbl_pkg::*;
#(
   parameter int ROW_W  = 6,
   parameter int BANK_W = 3,
   parameter int COL_PW = 2,
   parameter int CMP_N  = 32,
   parameter int IDX_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              in_valid,
   input  logic [ROW_W-1:0]  in_row,
   input  logic [BANK_W-1:0] in_bank,
   input  logic [COL_PW-1:0] in_col,
   input  logic [CMP_N-1:0]  in_vec,
   output logic              ready,
   output logic              sel_valid,
   output logic [IDX_W-1:0]  sel_idx,
   output logic [ROW_W-1:0]  sel_row,
   output logic [BANK_W-1:0] sel_bank,
   output logic [COL_PW-1:0] sel_col
);

   logic [CMP_N-1:0]  pend_vec;
   logic [ROW_W-1:0]  pend_row;
   logic [BANK_W-1:0] pend_bank;
   logic [COL_PW-1:0] pend_col;

   fbl_src_e          src;
   logic              take;
   logic [CMP_N-1:0]  work_vec;
   logic [CMP_N-1:0]  low_oh;

   assign ready = (pend_vec == '0);
   assign src   = ready ? SRC_INPUT : SRC_PEND;
   assign take  = in_valid && ready && !clear;

   always_comb begin
      if (src == SRC_PEND) begin
         work_vec = pend_vec;
         sel_row  = pend_row;
         sel_bank = pend_bank;
         sel_col  = pend_col;
      end else begin
         work_vec = take ? in_vec : '0;
         sel_row  = in_row;
         sel_bank = in_bank;
         sel_col  = in_col;
      end
   end

   assign low_oh    = work_vec & (~work_vec + CMP_N'(1));
   assign sel_valid = (work_vec != '0) && !clear;

   always_comb begin
      sel_idx = '0;
      for (int i = CMP_N - 1; i >= 0; i--) begin
         if (work_vec[i]) sel_idx = IDX_W'(i);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_vec  <= '0;
         pend_row  <= '0;
         pend_bank <= '0;
         pend_col  <= '0;
      end else if (clear) begin
         pend_vec  <= '0;
      end else begin
         pend_vec <= work_vec & ~low_oh;
         if (take) begin
            pend_row  <= in_row;
            pend_bank <= in_bank;
            pend_col  <= in_col;
         end
      end
   end

endmodule

// File: rtl/fbl_log_store.sv
module fbl_log_store #(
   parameter int ADDR_W    = 9,
   parameter int BIT_W     = 8,
   parameter int LOG_DEPTH = 8,
   parameter int CNT_W     = 12,
   parameter int LIDX_W    = 3,
   parameter int LCNT_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic [CNT_W-1:0]  limit_in,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BIT_W-1:0]  wr_bit,
   input  logic [LIDX_W-1:0] rd_idx,
   output logic              rd_valid,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [BIT_W-1:0]  rd_bit,
   output logic [LCNT_W-1:0] log_cnt,
   output logic [CNT_W-1:0]  ovf_cnt,
   output logic              stop_req
);

   localparam logic [CNT_W-1:0]  CMAX = '1;
   localparam logic [LCNT_W-1:0] FULL = LCNT_W'(LOG_DEPTH);

   logic [ADDR_W-1:0] addr_mem [LOG_DEPTH];
   logic [BIT_W-1:0]  bit_mem  [LOG_DEPTH];
   logic [CNT_W-1:0]  limit_q;
   logic [CNT_W-1:0]  err_cnt;
   logic [CNT_W-1:0]  err_nxt;
   logic              full;

   assign full    = (log_cnt == FULL);
   assign err_nxt = (wr_valid && err_cnt != CMAX) ? err_cnt + CNT_W'(1) : err_cnt;

   always_ff @(posedge clk) begin
      if (wr_valid && !full && !clear) begin
         addr_mem[log_cnt[LIDX_W-1:0]] <= wr_addr;
         bit_mem[log_cnt[LIDX_W-1:0]]  <= wr_bit;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         log_cnt  <= '0;
         ovf_cnt  <= '0;
         err_cnt  <= '0;
         limit_q  <= '0;
         stop_req <= 1'b0;
      end else if (clear) begin
         log_cnt  <= '0;
         ovf_cnt  <= '0;
         err_cnt  <= '0;
         limit_q  <= limit_in;
         stop_req <= 1'b0;
      end else begin
         err_cnt <= err_nxt;
         if (limit_q != '0 && err_nxt == limit_q) stop_req <= 1'b1;
         if (wr_valid) begin
            if (!full)                log_cnt <= log_cnt + LCNT_W'(1);
            else if (ovf_cnt != CMAX) ovf_cnt <= ovf_cnt + CNT_W'(1);
         end
      end
   end

   assign rd_valid = (LCNT_W'(rd_idx) < log_cnt);
   assign rd_addr  = rd_valid ? addr_mem[rd_idx] : '0;
   assign rd_bit   = rd_valid ? bit_mem[rd_idx] : '0;

endmodule

// File: rtl/fail_bitmap_logger.sv
module fail_bitmap_logger
   import fbl_pkg::*;
#(
   parameter int          ROW_W        = 6,
   parameter int          ROW_LO_W     = 2,
   parameter int          BANK_W       = 3,
   parameter int          COL_W        = 2,
   parameter int          CMP_N        = 32,
   parameter int          SPARE_BITS   = 4,
   parameter int          LOG_DEPTH    = 8,
   parameter int          CNT_W        = 12,
   parameter logic [31:0] ROW_INV_MASK = '0,
   localparam int         MUX_M        = 1 << COL_W,
   localparam int         COL_PW       = (COL_W > 0) ? COL_W : 1,
   localparam int         IDX_W        = fbl_w(CMP_N),
   localparam int         ADDR_W       = ROW_W + BANK_W,
   localparam int         BIT_W        = fbl_w(CMP_N * MUX_M + SPARE_BITS),
   localparam int         LIDX_W       = fbl_w(LOG_DEPTH),
   localparam int         LCNT_W       = fbl_w(LOG_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_start,
   input  logic [CNT_W-1:0]  err_limit,
   input  logic              fail_valid,
   input  logic [ROW_W-1:0]  fail_row,
   input  logic [BANK_W-1:0] fail_bank,
   input  logic [COL_PW-1:0] fail_col,
   input  logic [CMP_N-1:0]  fail_vec,
   output logic              fail_ready,
   output logic              stop_req,
   input  logic [LIDX_W-1:0] rd_idx,
   output logic              rd_valid,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [BIT_W-1:0]  rd_bit,
   output logic [LCNT_W-1:0] log_cnt,
   output logic [CNT_W-1:0]  ovf_cnt
);

   generate
      if (ROW_LO_W < 0 || ROW_LO_W > ROW_W) begin : g_bad_lo
         $error("ROW_LO_W must lie in 0..ROW_W");
      end
      if (ROW_W < 1 || BANK_W < 1 || CMP_N < 1) begin : g_bad_w
         $error("ROW_W, BANK_W and CMP_N must be at least 1");
      end
      if (COL_W < 0 || COL_W > 8) begin : g_bad_col
         $error("COL_W must lie in 0..8");
      end
      if (LOG_DEPTH < 1 || LOG_DEPTH > 1024 || CNT_W < 2) begin : g_bad_log
         $error("LOG_DEPTH must lie in 1..1024 and CNT_W be at least 2");
      end
      if (SPARE_BITS < 0) begin : g_bad_spare
         $error("SPARE_BITS must not be negative");
      end
   endgenerate

   logic              sel_valid;
   logic [IDX_W-1:0]  sel_idx;
   logic [ROW_W-1:0]  sel_row;
   logic [BANK_W-1:0] sel_bank;
   logic [COL_PW-1:0] sel_col;
   logic [ADDR_W-1:0] map_addr;
   logic [BIT_W-1:0]  map_bit;

   fbl_pick #(
      .ROW_W  (ROW_W),
      .BANK_W (BANK_W),
      .COL_PW (COL_PW),
      .CMP_N  (CMP_N),
      .IDX_W  (IDX_W)
   ) u_pick (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (run_start),
      .in_valid  (fail_valid),
      .in_row    (fail_row),
      .in_bank   (fail_bank),
      .in_col    (fail_col),
      .in_vec    (fail_vec),
      .ready     (fail_ready),
      .sel_valid (sel_valid),
      .sel_idx   (sel_idx),
      .sel_row   (sel_row),
      .sel_bank  (sel_bank),
      .sel_col   (sel_col)
   );

   fbl_addr_map #(
      .ROW_W        (ROW_W),
      .ROW_LO_W     (ROW_LO_W),
      .BANK_W       (BANK_W),
      .COL_W        (COL_W),
      .COL_PW       (COL_PW),
      .IDX_W        (IDX_W),
      .SPARE_BITS   (SPARE_BITS),
      .ROW_INV_MASK (ROW_INV_MASK),
      .ADDR_W       (ADDR_W),
      .BIT_W        (BIT_W)
   ) u_map (
      .row       (sel_row),
      .bank      (sel_bank),
      .col       (sel_col),
      .cmp_idx   (sel_idx),
      .word_addr (map_addr),
      .bit_idx   (map_bit)
   );

   fbl_log_store #(
      .ADDR_W    (ADDR_W),
      .BIT_W     (BIT_W),
      .LOG_DEPTH (LOG_DEPTH),
      .CNT_W     (CNT_W),
      .LIDX_W    (LIDX_W),
      .LCNT_W    (LCNT_W)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (run_start),
      .limit_in (err_limit),
      .wr_valid (sel_valid),
      .wr_addr  (map_addr),
      .wr_bit   (map_bit),
      .rd_idx   (rd_idx),
      .rd_valid (rd_valid),
      .rd_addr  (rd_addr),
      .rd_bit   (rd_bit),
      .log_cnt  (log_cnt),
      .ovf_cnt  (ovf_cnt),
      .stop_req (stop_req)
   );

endmodule

// File: rtl/fail_bitmap_logger_chk.sv
module fail_bitmap_logger_chk #(
   parameter int LOG_DEPTH = 8,
   parameter int NBITS     = 132,
   parameter int BIT_W     = 8,
   parameter int LCNT_W    = 4,
   parameter int CNT_W     = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              run_start,
   input logic              fail_ready,
   input logic              stop_req,
   input logic              rd_valid,
   input logic [BIT_W-1:0]  rd_bit,
   input logic [LCNT_W-1:0] log_cnt,
   input logic [CNT_W-1:0]  ovf_cnt
);

   AST_STOP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      stop_req && !run_start |=> stop_req); // R7

   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      run_start |=> (log_cnt == '0 && ovf_cnt == '0 && !stop_req && fail_ready)); // R8

   AST_LOG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      int'(log_cnt) <= LOG_DEPTH); // R5

   AST_OVF_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_cnt != '0 |-> int'(log_cnt) == LOG_DEPTH); // R6

   AST_ONE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      !run_start |=> (int'(log_cnt) == int'($past(log_cnt))
                      || int'(log_cnt) == int'($past(log_cnt)) + 1)); // R4

   AST_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> int'(rd_bit) < NBITS); // R2

endmodule

bind fail_bitmap_logger fail_bitmap_logger_chk #(
   .LOG_DEPTH (LOG_DEPTH),
   .NBITS     (CMP_N * MUX_M + SPARE_BITS),
   .BIT_W     (BIT_W),
   .LCNT_W    (LCNT_W),
   .CNT_W     (CNT_W)
) u_chk (.*);

// File: tb/fail_bitmap_logger_tb_top.sv
`timescale 1ns/1ps
module fail_bitmap_logger_tb_top;

   // default configuration: 6 row bits (2 low), 3 bank bits, mux 4, 32 comparators, 4 spares
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_start = 1'b0;
   logic [11:0] err_limit = '0;
   logic        fail_valid = 1'b0;
   logic [5:0]  fail_row = '0;
   logic [2:0]  fail_bank = '0;
   logic [1:0]  fail_col = '0;
   logic [31:0] fail_vec = '0;
   logic        fail_ready, stop_req, rd_valid;
   logic [2:0]  rd_idx = '0;
   logic [8:0]  rd_addr;
   logic [7:0]  rd_bit;
   logic [3:0]  log_cnt;
   logic [11:0] ovf_cnt;

   // second configuration: no column mux, row bit 0 inverted, no spares
   logic        n_run_start = 1'b0;
   logic        n_fail_valid = 1'b0;
   logic [3:0]  n_fail_row = '0;
   logic [0:0]  n_fail_bank = '0;
   logic [0:0]  n_fail_col = '0;
   logic [255:0] n_fail_vec = '0;
   logic        n_fail_ready, n_stop_req, n_rd_valid;
   logic [1:0]  n_rd_idx = '0;
   logic [4:0]  n_rd_addr;
   logic [7:0]  n_rd_bit;
   logic [2:0]  n_log_cnt;
   logic [7:0]  n_ovf_cnt;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   fail_bitmap_logger dut_i (
      .clk(clk), .rst_n(rst_n), .run_start(run_start), .err_limit(err_limit),
      .fail_valid(fail_valid), .fail_row(fail_row), .fail_bank(fail_bank),
      .fail_col(fail_col), .fail_vec(fail_vec), .fail_ready(fail_ready),
      .stop_req(stop_req), .rd_idx(rd_idx), .rd_valid(rd_valid),
      .rd_addr(rd_addr), .rd_bit(rd_bit), .log_cnt(log_cnt), .ovf_cnt(ovf_cnt)
   );

   fail_bitmap_logger #(
      .ROW_W(4), .ROW_LO_W(2), .BANK_W(1), .COL_W(0), .CMP_N(256),
      .SPARE_BITS(0), .LOG_DEPTH(4), .CNT_W(8), .ROW_INV_MASK(32'h1)
   ) dut2_i (
      .clk(clk), .rst_n(rst_n), .run_start(n_run_start), .err_limit(8'd0),
      .fail_valid(n_fail_valid), .fail_row(n_fail_row), .fail_bank(n_fail_bank),
      .fail_col(n_fail_col), .fail_vec(n_fail_vec), .fail_ready(n_fail_ready),
      .stop_req(n_stop_req), .rd_idx(n_rd_idx), .rd_valid(n_rd_valid),
      .rd_addr(n_rd_addr), .rd_bit(n_rd_bit), .log_cnt(n_log_cnt), .ovf_cnt(n_ovf_cnt)
   );

   function automatic int exp_addr(int row, int bank);
      return ((row >> 2) << 5) | (bank << 2) | (row & 3);
   endfunction

   function automatic int exp_bit(int cmp, int col);
      return cmp * 4 + col + 4;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic start_run(input int limit);
      @(negedge clk);
      run_start = 1'b1;
      err_limit = 12'(limit);
      @(negedge clk);
      run_start = 1'b0;
   endtask

   task automatic send(input int row, input int bank, input int col, input logic [31:0] vec);
      @(negedge clk);
      fail_valid = 1'b1;
      fail_row   = 6'(row);
      fail_bank  = 3'(bank);
      fail_col   = 2'(col);
      fail_vec   = vec;
      @(negedge clk);
      fail_valid = 1'b0;
      fail_vec   = '0;
      while (!fail_ready) @(negedge clk);
   endtask

   task automatic read_entry(input int idx, output int a, output int b, output bit v);
      rd_idx = 3'(idx);
      #1;
      a = int'(rd_addr);
      b = int'(rd_bit);
      v = rd_valid;
   endtask

   task automatic t_reset;
      check(log_cnt == 0, "R9", "log_cnt after reset", int'(log_cnt), 0);
      check(ovf_cnt == 0, "R9", "ovf_cnt after reset", int'(ovf_cnt), 0);
      check(!stop_req, "R9", "stop_req after reset", int'(stop_req), 0);
      check(fail_ready, "R9", "fail_ready after reset", int'(fail_ready), 1);
   endtask

   task automatic t_mapping;
      int a, b;
      bit v;
      start_run(0);
      // row 000011, bank 111, col 01, comparator 3 -> word 31, bit 17
      send(6'b000011, 3'b111, 1, 32'h8);
      read_entry(0, a, b, v);
      check(v, "R5", "entry0 valid", int'(v), 1);
      check(a == 31, "R1", "word address of example", a, 31);
      check(b == 17, "R2", "bit index of example", b, 17);
      send(6'b101100, 3'b010, 3, 32'h8000_0000);
      read_entry(1, a, b, v);
      check(a == exp_addr(6'b101100, 2), "R1", "word address high row bits", a,
            exp_addr(6'b101100, 2));
      check(b == exp_bit(31, 3), "R2", "bit index top comparator", b, exp_bit(31, 3));
      read_entry(2, a, b, v);
      check(!v && a == 0, "R5", "unwritten entry invalid", int'(v), 0);
   endtask

   task automatic t_multi;
      int a, b;
      bit v;
      start_run(0);
      @(negedge clk);
      fail_valid = 1'b1;
      fail_row   = 6'd9;
      fail_bank  = 3'd5;
      fail_col   = 2'd2;
      fail_vec   = 32'h0010_0088; // comparators 3, 7, 20
      @(negedge clk);
      fail_valid = 1'b0;
      fail_vec   = '0;
      fail_row   = 6'd0;
      check(!fail_ready, "R4", "ready low while bits wait", int'(fail_ready), 0);
      check(log_cnt == 1, "R4", "first bit logged at once", int'(log_cnt), 1);
      @(negedge clk);
      check(!fail_ready && log_cnt == 2, "R4", "second bit next cycle", int'(log_cnt), 2);
      @(negedge clk);
      check(fail_ready && log_cnt == 3, "R4", "third bit and ready back", int'(log_cnt), 3);
      read_entry(0, a, b, v);
      check(b == exp_bit(3, 2), "R4", "lowest comparator first", b, exp_bit(3, 2));
      read_entry(1, a, b, v);
      check(b == exp_bit(7, 2), "R4", "middle comparator second", b, exp_bit(7, 2));
      read_entry(2, a, b, v);
      check(b == exp_bit(20, 2), "R4", "highest comparator last", b, exp_bit(20, 2));
      check(a == exp_addr(9, 5), "R1", "address kept for waiting bits", a, exp_addr(9, 5));
   endtask

   task automatic t_overflow;
      int a, b;
      bit v;
      start_run(0);
      for (int i = 0; i < 11; i++) send(i, 1, 0, 32'(1) << i);
      check(log_cnt == 8, "R5", "log holds depth entries", int'(log_cnt), 8);
      check(ovf_cnt == 3, "R6", "overflow counts late fails", int'(ovf_cnt), 3);
      read_entry(7, a, b, v);
      check(v && b == exp_bit(7, 0), "R6", "last stored entry kept", b, exp_bit(7, 0));
      read_entry(0, a, b, v);
      check(b == exp_bit(0, 0) && a == exp_addr(0, 1), "R5", "first entry kept", b,
            exp_bit(0, 0));
      check(!stop_req, "R7", "limit 0 never stops", int'(stop_req), 0);
   endtask

   task automatic t_stop;
      start_run(3);
      send(1, 0, 0, 32'h0000_0101);
      check(!stop_req, "R7", "no stop below limit", int'(stop_req), 0);
      send(2, 0, 0, 32'h0000_0002);
      check(stop_req, "R7", "stop at limit", int'(stop_req), 1);
      send(3, 0, 0, 32'h0000_0004);
      check(stop_req, "R7", "stop stays high", int'(stop_req), 1);
   endtask

   task automatic t_start_drops;
      @(negedge clk);
      run_start  = 1'b1;
      err_limit  = 12'd0;
      fail_valid = 1'b1;
      fail_vec   = 32'h1;
      @(negedge clk);
      run_start  = 1'b0;
      fail_valid = 1'b0;
      fail_vec   = '0;
      @(negedge clk);
      check(log_cnt == 0, "R8", "fail with start dropped", int'(log_cnt), 0);
      check(!stop_req && ovf_cnt == 0, "R8", "start clears stop and overflow",
            int'(stop_req), 0);
   endtask

   task automatic t_nomux;
      @(negedge clk);
      n_run_start = 1'b1;
      @(negedge clk);
      n_run_start  = 1'b0;
      n_fail_valid = 1'b1;
      n_fail_row   = 4'b0100;
      n_fail_bank  = 1'b1;
      n_fail_col   = 1'b1;
      n_fail_vec   = 256'(1) << 8;
      @(negedge clk);
      n_fail_valid = 1'b0;
      n_fail_vec   = '0;
      n_rd_idx     = 2'd0;
      #1;
      // row 0100 with bit 0 inverted -> 0101 -> {01,1,01} = 13
      check(n_rd_addr == 5'd13, "R3", "inverted row bit in address", int'(n_rd_addr), 13);
      check(n_rd_bit == 8'd8, "R2", "no mux bit equals comparator", int'(n_rd_bit), 8);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mapping();
      t_multi();
      t_overflow();
      t_stop();
      t_start_drops();
      t_nomux();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule